// File: doc/BRIEF.md
# Threshold Interrupt and Flag Controller

This block sits beside a periodic measurement engine and decides when to raise an interrupt line. Each time the engine signals a finished conversion, the block takes the unsigned result and compares it against a high and a low limit. A small filter then requires a programmable number of consecutive out-of-range results before it trips. The block keeps three status bits: above-high, below-low and a new-result bit. It drives one interrupt pin with programmable polarity.

There are three reporting styles. In latched window mode a tripped condition stays recorded until software reads the configuration. In transparent mode the interrupt follows a hysteresis band. In end-of-conversion mode, chosen by a two-bit code carried in the low-limit register, every finished conversion raises the interrupt. The register interface drives three kinds of clearing access: a configuration read strobe, a configuration write strobe carrying its mode, latch and polarity fields, and an alert-response strobe. Each access clears a different subset of the state.

Top module: `thr_irq_ctrl`

## Requirements
- R1: After reset, flag_hi, flag_lo and conv_rdy are 0, the latch field is 1, the polarity field is 0 (active-low) and irq_pin is 1 (inactive).
- R2: flag_hi trips when result > hi_limit (unsigned) on N consecutive conversions, where N = 1 << fault_sel (fault_sel 0,1,2,3 gives 1,2,4,8). flag_lo trips in the same way when result < lo_limit. A conversion that is not outside the limit restarts the count for that side.
- R3: conv_rdy is 1 in the cycle after every conv_done pulse, in all modes.
- R4: With latch = 1 and lim_mode not 2'b11, a tripped flag stays 1 until a configuration read. The interrupt becomes active on a trip and stays active until a configuration read or an alert response.
- R5: With latch = 0 (transparent), a high trip sets flag_hi, clears flag_lo and activates the interrupt. A low trip sets flag_lo, clears flag_hi and deactivates the interrupt.
- R6: With lim_mode = 2'b11 (end-of-conversion), every conversion activates the interrupt, whether or not a limit tripped.
- R7: A configuration read (cfg_rd) clears flag_hi, flag_lo and conv_rdy and deactivates the interrupt.
- R8: A configuration write with cfg_wr_mode = 2'b00 (shutdown) leaves flag_hi, flag_lo, conv_rdy and the interrupt unchanged.
- R9: A configuration write with cfg_wr_mode other than 2'b00 clears conv_rdy and leaves flag_hi and flag_lo unchanged.
- R10: An alert response (alert_ack) deactivates the interrupt and leaves flag_hi, flag_lo and conv_rdy unchanged.
- R11: If lim_mode steps from 2'b11 to 2'b00 while latch is 1 and the interrupt is active, the interrupt stays active through reads and alert responses. It releases only when a configuration write carries cfg_wr_latch = 0.
- R12: Every configuration write loads the latch field from cfg_wr_latch and the polarity field from cfg_wr_pol. With polarity 0, irq_pin is 0 when the interrupt is active; with polarity 1, irq_pin is 1 when active.
- R13: When conv_done coincides with a clearing access (read, write or alert), the new conversion's setting effects win, so its trip, new-result bit and interrupt are not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle pulse: a conversion finished and result is valid |
| result | input | DATA_W | Conversion result, unsigned |
| hi_limit | input | DATA_W | Upper threshold |
| lo_limit | input | DATA_W | Lower threshold |
| lim_mode | input | 2 | Reporting code from the low-limit register; 2'b11 selects end-of-conversion |
| fault_sel | input | SEL_W | Consecutive-fault count select, N = 1 << fault_sel |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wr_mode | input | 2 | Mode field of the write; 2'b00 means shutdown |
| cfg_wr_latch | input | 1 | Latch field of the write |
| cfg_wr_pol | input | 1 | Polarity field of the write |
| alert_ack | input | 1 | Alert-response strobe |
| flag_hi | output | 1 | Above-high status |
| flag_lo | output | 1 | Below-low status |
| conv_rdy | output | 1 | New-result status |
| irq_pin | output | 1 | Interrupt pin, polarity set by configuration |

## Verification
The bench builds the block with its default widths: 16-bit data and a 2-bit fault select. That makes every count of 1, 2, 4 and 8 consecutive faults reachable, and the saturation of the 4-bit counters is exercised once the select changes while a run is in progress. Random results are drawn close to both limits, so runs of faults break and restart often. The limits are occasionally moved or crossed, so both filters can trip in the same conversion. End-of-conversion entry and exit, writes of every mode, polarity and latch value, and collisions between a conversion and clearing strobes all arise in the random phase. Directed sequences also pin down the exit-hold release and each clearing rule.

// File: rtl/thr_pkg.sv
package thr_pkg;
   localparam logic [1:0] EOC_CODE      = 2'b11;
   localparam logic [1:0] CMP_CODE      = 2'b00;
   localparam logic [1:0] MODE_SHUTDOWN = 2'b00;
   typedef enum logic {CMP_HIGH = 1'b0, CMP_LOW = 1'b1} cmp_dir_e;
endpackage

// File: rtl/thr_fault_filter.sv
module thr_fault_filter
   import thr_pkg::*;
#(
   parameter int       DATA_W = 16,
   parameter int       SEL_W  = 2,
   parameter cmp_dir_e DIR    = CMP_HIGH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] result,
   input  logic [DATA_W-1:0] limit,
   input  logic [SEL_W-1:0]  fault_sel,
   output logic              hit
);
   localparam int MAXN  = 1 << ((1 << SEL_W) - 1);
   localparam int CNT_W = $clog2(MAXN + 1);

   logic             outside;
   logic [CNT_W-1:0] cnt, cnt_inc;
   logic [CNT_W:0]   need;

   if (DIR == CMP_HIGH) begin : g_above
      assign outside = result > limit;
   end else begin : g_below
      assign outside = result < limit;
   end

   assign cnt_inc = (cnt == CNT_W'(MAXN)) ? cnt : cnt + 1'b1;
   assign need    = (CNT_W + 1)'(1) << fault_sel;
   assign hit     = conv_done & outside & ({1'b0, cnt_inc} >= need);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (conv_done) cnt <= outside ? cnt_inc : '0;
   end
endmodule

// File: rtl/thr_irq_state.sv
module thr_irq_state
   import thr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       conv_done,
   input  logic       hi_hit,
   input  logic       lo_hit,
   input  logic       eoc_on,
   input  logic       latch_q,
   input  logic       cfg_rd,
   input  logic       cfg_wr,
   input  logic [1:0] cfg_wr_mode,
   input  logic       alert_ack,
   output logic       flag_hi,
   output logic       flag_lo,
   output logic       conv_rdy,
   output logic       int_act
);
   logic fh_n, fl_n, cr_n, act_n, act_base;

   always_comb begin
      // clearing accesses are applied first; the conversion then overrides them
      fh_n = cfg_rd ? 1'b0 : flag_hi;
      fl_n = cfg_rd ? 1'b0 : flag_lo;
      if (latch_q) begin
         if (hi_hit) fh_n = 1'b1;
         if (lo_hit) fl_n = 1'b1;
      end else begin
         if (hi_hit)      begin fh_n = 1'b1; fl_n = 1'b0; end
         else if (lo_hit) begin fl_n = 1'b1; fh_n = 1'b0; end
      end

      cr_n = (cfg_rd || (cfg_wr && cfg_wr_mode != MODE_SHUTDOWN)) ? 1'b0 : conv_rdy;
      if (conv_done) cr_n = 1'b1;

      act_base = (cfg_rd || alert_ack) ? 1'b0 : int_act;
      act_n    = act_base;
      if (conv_done) begin
         if (eoc_on)       act_n = 1'b1;
         else if (latch_q) act_n = act_base | hi_hit | lo_hit;
         else if (hi_hit)  act_n = 1'b1;
         else if (lo_hit)  act_n = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_hi  <= 1'b0;
         flag_lo  <= 1'b0;
         conv_rdy <= 1'b0;
         int_act  <= 1'b0;
      end else begin
         flag_hi  <= fh_n;
         flag_lo  <= fl_n;
         conv_rdy <= cr_n;
         int_act  <= act_n;
      end
   end
endmodule

// File: rtl/thr_irq_ctrl.sv
module thr_irq_ctrl
   import thr_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] result,
   input  logic [DATA_W-1:0] hi_limit,
   input  logic [DATA_W-1:0] lo_limit,
   input  logic [1:0]        lim_mode,
   input  logic [SEL_W-1:0]  fault_sel,
   input  logic              cfg_rd,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_wr_mode,
   input  logic              cfg_wr_latch,
   input  logic              cfg_wr_pol,
   input  logic              alert_ack,
   output logic              flag_hi,
   output logic              flag_lo,
   output logic              conv_rdy,
   output logic              irq_pin
);
   if (DATA_W < 2) begin : g_bad_width
      $error("thr_irq_ctrl: DATA_W must be at least 2");
   end
   if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
      $error("thr_irq_ctrl: SEL_W must lie in 1..3");
   end

   logic [1:0] hit;
   logic       latch_q, pol_q, hold_q, int_act;
   logic [1:0] mode_prev;
   logic       active;

   for (genvar d = 0; d < 2; d++) begin : g_flt
      thr_fault_filter #(
         .DATA_W (DATA_W),
         .SEL_W  (SEL_W),
         .DIR    (d == 0 ? CMP_HIGH : CMP_LOW)
      ) u_flt (
         .clk       (clk),
         .rst_n     (rst_n),
         .conv_done (conv_done),
         .result    (result),
         .limit     (d == 0 ? hi_limit : lo_limit),
         .fault_sel (fault_sel),
         .hit       (hit[d])
      );
   end

   thr_irq_state u_state (
      .clk         (clk),
      .rst_n       (rst_n),
      .conv_done   (conv_done),
      .hi_hit      (hit[0]),
      .lo_hit      (hit[1]),
      .eoc_on      (lim_mode == EOC_CODE),
      .latch_q     (latch_q),
      .cfg_rd      (cfg_rd),
      .cfg_wr      (cfg_wr),
      .cfg_wr_mode (cfg_wr_mode),
      .alert_ack   (alert_ack),
      .flag_hi     (flag_hi),
      .flag_lo     (flag_lo),
      .conv_rdy    (conv_rdy),
      .int_act     (int_act)
   );

   assign active = int_act | hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q   <= 1'b1;
         pol_q     <= 1'b0;
         hold_q    <= 1'b0;
         mode_prev <= CMP_CODE;
      end else begin
         mode_prev <= lim_mode;
         if (cfg_wr) begin
            latch_q <= cfg_wr_latch;
            pol_q   <= cfg_wr_pol;
         end
         if (cfg_wr && !cfg_wr_latch)
            hold_q <= 1'b0;
         else if (mode_prev == EOC_CODE && lim_mode == CMP_CODE && latch_q && active)
            hold_q <= 1'b1;
      end
   end

   assign irq_pin = pol_q ? active : ~active;
endmodule

// File: rtl/thr_irq_chk.sv
module thr_irq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       conv_done,
   input logic       cfg_rd,
   input logic       cfg_wr,
   input logic [1:0] cfg_wr_mode,
   input logic       alert_ack,
   input logic [1:0] lim_mode,
   input logic       flag_hi,
   input logic       flag_lo,
   input logic       conv_rdy,
   input logic       irq_pin,
   input logic       pol_q
);
   // R3
   conv_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |=> conv_rdy);
   // R6
   eoc_raises_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && lim_mode == 2'b11) |=> (irq_pin == pol_q));
   // R7
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd && !conv_done) |=> (!flag_hi && !flag_lo && !conv_rdy));
   // R8
   shutdown_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_wr_mode == 2'b00 && !conv_done && !cfg_rd)
         |=> ($stable(flag_hi) && $stable(flag_lo) && $stable(conv_rdy)));
   // R9
   active_write_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_wr_mode != 2'b00 && !conv_done) |=> !conv_rdy);
   // R10
   alert_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alert_ack && !conv_done && !cfg_rd && !cfg_wr)
         |=> ($stable(flag_hi) && $stable(flag_lo) && $stable(conv_rdy)));
endmodule

bind thr_irq_ctrl thr_irq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .conv_done   (conv_done),
   .cfg_rd      (cfg_rd),
   .cfg_wr      (cfg_wr),
   .cfg_wr_mode (cfg_wr_mode),
   .alert_ack   (alert_ack),
   .lim_mode    (lim_mode),
   .flag_hi     (flag_hi),
   .flag_lo     (flag_lo),
   .conv_rdy    (conv_rdy),
   .irq_pin     (irq_pin),
   .pol_q       (pol_q)
);

// File: tb/tb_thr_irq_ctrl.sv
`timescale 1ns/1ps
module tb_thr_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        conv_done = 1'b0;
   logic [15:0] result = '0, hi_limit = 16'h8000, lo_limit = 16'h2000;
   logic [1:0]  lim_mode = 2'b00;
   logic [1:0]  fault_sel = 2'd0;
   logic        cfg_rd = 1'b0, cfg_wr = 1'b0, cfg_wr_latch = 1'b0, cfg_wr_pol = 1'b0, alert_ack = 1'b0;
   logic [1:0]  cfg_wr_mode = 2'b00;
   logic        flag_hi, flag_lo, conv_rdy, irq_pin;

   int checks = 0, fails = 0;
   bit done = 0;

   // reference state
   int m_hc = 0, m_lc = 0;
   bit m_fh = 0, m_fl = 0, m_cr = 0, m_act = 0, m_hold = 0, m_latch = 1, m_pol = 0;
   logic [1:0] m_prev = 2'b00;

   always #4 clk = ~clk;

   thr_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .result(result),
      .hi_limit(hi_limit), .lo_limit(lo_limit), .lim_mode(lim_mode),
      .fault_sel(fault_sel), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
      .cfg_wr_mode(cfg_wr_mode), .cfg_wr_latch(cfg_wr_latch),
      .cfg_wr_pol(cfg_wr_pol), .alert_ack(alert_ack),
      .flag_hi(flag_hi), .flag_lo(flag_lo), .conv_rdy(conv_rdy), .irq_pin(irq_pin)
   );

   function automatic bit exp_pin();
      return m_pol ? (m_act | m_hold) : ~(m_act | m_hold);
   endfunction

   task automatic chk(input string tag, input string what, input bit act, input bit exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic check_all(input string tag);
      chk(tag, "flag_hi", flag_hi, m_fh);
      chk(tag, "flag_lo", flag_lo, m_fl);
      chk(tag, "conv_rdy", conv_rdy, m_cr);
      chk(tag, "irq_pin", irq_pin, exp_pin());
   endtask

   // one clock: drive at the falling edge, update the reference, sample after the rising edge
   task automatic step(input string tag, input bit cd, input logic [15:0] res,
                       input bit rd, input bit wr, input logic [1:0] wm, input bit wl,
                       input bit wp, input bit al, input logic [1:0] mode);
      int  need, hinc, linc;
      bit  hh, lh, hout, lout, a, old_act, old_hold;
      @(negedge clk);
      conv_done = cd; result = res; cfg_rd = rd; cfg_wr = wr; cfg_wr_mode = wm;
      cfg_wr_latch = wl; cfg_wr_pol = wp; alert_ack = al; lim_mode = mode;
      need = 1 << fault_sel;
      hout = res > hi_limit;
      lout = res < lo_limit;
      hinc = (m_hc == 8) ? 8 : m_hc + 1;
      linc = (m_lc == 8) ? 8 : m_lc + 1;
      hh = cd && hout && (hinc >= need);
      lh = cd && lout && (linc >= need);
      if (cd) begin
         m_hc = hout ? hinc : 0;
         m_lc = lout ? linc : 0;
      end
      old_act = m_act; old_hold = m_hold;
      if (rd) begin m_fh = 0; m_fl = 0; end
      if (m_latch) begin
         if (hh) m_fh = 1;
         if (lh) m_fl = 1;
      end else if (hh) begin m_fh = 1; m_fl = 0; end
      else if (lh) begin m_fl = 1; m_fh = 0; end
      if (rd || (wr && wm != 2'b00)) m_cr = 0;
      if (cd) m_cr = 1;
      a = (rd || al) ? 0 : m_act;
      if (cd) begin
         if (mode == 2'b11) a = 1;
         else if (m_latch)  a = a | hh | lh;
         else if (hh)       a = 1;
         else if (lh)       a = 0;
      end
      m_act = a;
      if (wr && !wl) m_hold = 0;
      else if (m_prev == 2'b11 && mode == 2'b00 && m_latch && (old_act || old_hold)) m_hold = 1;
      m_prev = mode;
      if (wr) begin m_latch = wl; m_pol = wp; end
      @(posedge clk);
      #2;
      check_all(tag);
   endtask

   task automatic conv(input string tag, input logic [15:0] res, input logic [1:0] mode);
      step(tag, 1, res, 0, 0, 2'b00, 0, 0, 0, mode);
   endtask

   task automatic idle(input string tag, input logic [1:0] mode);
      step(tag, 0, 16'h0, 0, 0, 2'b00, 0, 0, 0, mode);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      process::self().srandom(32'd7);
      repeat (3) @(posedge clk);
      #2;
      // R1 reset state
      check_all("R1");
      @(negedge clk); rst_n = 1'b1;
      idle("R1", 2'b00);

      // R2 R4 single-fault trip in latched window mode
      fault_sel = 2'd0;
      conv("R2", 16'h9000, 2'b00);
      conv("R4", 16'h5000, 2'b00);
      // R10 alert releases interrupt, keeps flags
      step("R10", 0, 0, 0, 0, 2'b00, 0, 0, 1, 2'b00);
      // R7 read clears
      step("R7", 0, 0, 1, 0, 2'b00, 0, 0, 0, 2'b00);

      // R2 four consecutive faults needed; an in-range result restarts
      fault_sel = 2'd2;
      repeat (3) conv("R2", 16'hA000, 2'b00);
      conv("R2", 16'h4000, 2'b00);
      repeat (3) conv("R2", 16'hA000, 2'b00);
      conv("R2", 16'hA000, 2'b00);
      repeat (4) conv("R2", 16'h1000, 2'b00);
      step("R7", 0, 0, 1, 0, 2'b00, 0, 0, 0, 2'b00);

      // R8 shutdown write keeps state; R9 active write clears only conv_rdy
      fault_sel = 2'd0;
      conv("R3", 16'h9000, 2'b00);
      step("R8", 0, 0, 0, 1, 2'b00, 1, 0, 0, 2'b00);
      step("R9", 0, 0, 0, 1, 2'b01, 1, 0, 0, 2'b00);
      step("R7", 0, 0, 1, 0, 2'b00, 0, 0, 0, 2'b00);

      // R6 every conversion raises interrupt in end-of-conversion mode
      conv("R6", 16'h5000, 2'b11);
      step("R7", 0, 0, 1, 0, 2'b00, 0, 0, 0, 2'b11);
      conv("R6", 16'h5000, 2'b11);

      // R11 leaving end-of-conversion mode with latch set holds the interrupt
      idle("R11", 2'b00);
      step("R11", 0, 0, 1, 0, 2'b00, 0, 0, 0, 2'b00);
      step("R11", 0, 0, 0, 0, 2'b00, 0, 0, 1, 2'b00);
      step("R11", 0, 0, 0, 1, 2'b01, 0, 0, 0, 2'b00);
      step("R11", 0, 0, 0, 1, 2'b01, 1, 0, 0, 2'b00);

      // R5 transparent hysteresis
      step("R5", 0, 0, 0, 1, 2'b01, 0, 0, 0, 2'b00);
      conv("R5", 16'hC000, 2'b00);
      conv("R5", 16'h5000, 2'b00);
      conv("R5", 16'h0100, 2'b00);

      // R12 polarity to active-high, then back
      step("R12", 0, 0, 0, 1, 2'b01, 1, 1, 0, 2'b00);
      conv("R12", 16'hC000, 2'b00);
      step("R12", 0, 0, 0, 1, 2'b01, 1, 0, 0, 2'b00);

      // R13 conversion wins over a same-cycle read and alert
      step("R7", 0, 0, 1, 0, 2'b00, 0, 0, 0, 2'b00);
      step("R13", 1, 16'hC000, 1, 0, 2'b00, 0, 0, 1, 2'b00);
      step("R13", 1, 16'h5000, 0, 1, 2'b10, 1, 0, 0, 2'b11);

      // constrained random mix
      for (int i = 0; i < 4000; i++) begin
         int  r;
         logic [15:0] res;
         logic [1:0]  md;
         if ($urandom_range(0, 49) == 0) fault_sel = 2'($urandom_range(0, 3));
         if ($urandom_range(0, 199) == 0) begin
            hi_limit = 16'($urandom_range(16'h6000, 16'hA000));
            lo_limit = 16'($urandom_range(16'h1000, 16'h7000));
         end
         r   = $urandom_range(0, 2);
         res = (r == 0) ? 16'(hi_limit + $urandom_range(0, 2) - 1)
             : (r == 1) ? 16'(lo_limit + $urandom_range(0, 2) - 1)
             : 16'($urandom);
         md  = ($urandom_range(0, 9) < 7) ? 2'b00 : (($urandom_range(0, 3) == 0) ? 2'b01 : 2'b11);
         step("R2 R13 random",
              $urandom_range(0, 2) != 0, res,
              $urandom_range(0, 9) == 0, $urandom_range(0, 11) == 0,
              2'($urandom_range(0, 3)), $urandom_range(0, 3) != 0,
              $urandom_range(0, 7) == 0, $urandom_range(0, 9) == 0, md);
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule